// File: doc/BRIEF.md
# Two-Stage Prioritising Interrupt Controller

This block collects up to 32 peripheral interrupt sources and presents two request lines to a processor: a fast request and a normal request. Every source event is first latched in a source-pending register. One source may be marked as the fast source. While it pends, the fast request is raised at once, without passing through masking or arbitration. All other pending sources are filtered by a mask register. The survivors go to a fixed-priority picker, which writes the winner into a one-entry interrupt-pending register. The normal request stays high for as long as that register holds a bit.

Software reaches the block through a small word-addressed register port. Both pending registers are write-one-to-clear. An index register reports the number of the source that currently occupies the interrupt-pending register. A handler should clear its bit in the source-pending register before it clears the interrupt-pending register. If it does it the other way round, the same source is selected again on the following cycle.

Register addresses: 0 source-pending (W1C), 1 fast-select, 2 mask, 3 interrupt-pending (W1C), 4 index (read-only, number in bits [4:0]). Other addresses read zero.

Top module: `intc_core`

## Requirements
- R1: After reset, source-pending, fast-select and interrupt-pending read 0, mask reads all ones, index reads 0, and both request outputs are low.
- R2: A high bit on `src_evt` at a clock edge sets the matching source-pending bit at that edge. Several bits may be set in the same cycle.
- R3: Writing address 0 clears only the source-pending bits written as 1. A source event in the same cycle as a clear of its bit leaves that bit set.
- R4: A write to address 1 keeps only the lowest-numbered set bit of the write data, so at most one source is fast. The stored value reads back.
- R5: `fast_req` is high whenever the fast source's pending bit is set, even if that source's mask bit is 1. The fast source is never loaded into the interrupt-pending register.
- R6: A source whose mask bit is 1 is never loaded into the interrupt-pending register.
- R7: Among unmasked, non-fast pending sources, the lowest index wins. The interrupt-pending register holds at most one set bit.
- R8: The interrupt-pending register is loaded only in a cycle when it is zero. A higher-priority source arriving while it is occupied does not displace the occupant.
- R9: `norm_req` is high exactly while the interrupt-pending register is non-zero. A source event seen at one edge appears there at the next edge.
- R10: Clearing the interrupt-pending bit while the source-pending bit is still set makes the register read 0 for one cycle, after which the same source is selected again.
- R11: Address 4 returns the number of the set interrupt-pending bit, and 0 when none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt | input | NUM_SRC | Per-source event, one bit per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Register read data (combinational) |
| fast_req | output | 1 | Fast interrupt request |
| norm_req | output | 1 | Normal interrupt request |

## Verification
Two situations are the hardest to reach from the ports. The first is a source event that lands in the very cycle a clear is written to the same bit. The bench gets there by raising `src_evt` and the write strobe on the same falling edge, and clears a neighbouring bit in that write so that the two outcomes differ. The second is a higher-priority source arriving while the second stage is occupied. The bench loads a low-priority source, lets it settle, pulses a higher-priority one, and checks that the occupant stays until software clears it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_SRCP  = 3'd0,
    REG_MODE  = 3'd1,
    REG_MASK  = 3'd2,
    REG_INTP  = 3'd3,
    REG_INDEX = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/intc_prio_pick.sv
// Fixed-priority picker: the lowest set index wins, and the result is one-hot or zero.
module intc_prio_pick #(
  parameter int N = 32
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_src_pend.sv
// First stage: latches source events, cleared by write-one-to-clear. An event beats a clear.
module intc_src_pend #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_q;
  logic [N-1:0] pend_d;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_bit
      assign pend_d[gi] = (pend_q[gi] & ~(clr_en & clr_bits[gi])) | evt[gi];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/intc_cfg.sv
// Fast-select and mask registers. Fast-select keeps only the lowest written bit.
module intc_cfg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_we,
  input  logic         mask_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mode,
  output logic [N-1:0] mask
);
  logic [N-1:0] mode_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] mode_d;

  intc_prio_pick #(.N(N)) u_mode_pick (
    .req   (wdata),
    .grant (mode_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_we) begin
      mask_q <= wdata;
    end
  end

  assign mode = mode_q;
  assign mask = mask_q;
endmodule

// File: rtl/intc_int_pend.sv
// Second stage: one-entry pending register, loaded only while empty, plus index encoder.
module intc_int_pend #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     win,
  input  logic             clr_en,
  input  logic [N-1:0]     clr_bits,
  output logic [N-1:0]     pend,
  output logic [IDX_W-1:0] index
);
  logic [N-1:0]     pend_q;
  logic [N-1:0]     pend_d;
  logic             empty;
  logic             ld_en;
  logic [IDX_W-1:0] idx_c;

  assign empty = (pend_q == '0);
  assign ld_en = empty | clr_en;

  always_comb begin
    if (empty) begin
      pend_d = win;
    end else begin
      pend_d = pend_q & ~clr_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (ld_en) begin
      pend_q <= pend_d;
    end
  end

  always_comb begin
    idx_c = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_q[i]) idx_c = idx_c | IDX_W'(i);
    end
  end

  assign pend  = pend_q;
  assign index = idx_c;
endmodule

// File: rtl/intc_core.sv
module intc_core #(
  parameter int NUM_SRC = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          src_evt,
  input  logic                        reg_we,
  input  logic [intc_pkg::ADDR_W-1:0] reg_addr,
  input  logic [NUM_SRC-1:0]          reg_wdata,
  output logic [NUM_SRC-1:0]          reg_rdata,
  output logic                        fast_req,
  output logic                        norm_req
);
  import intc_pkg::*;

  localparam int IDX_W = $clog2(NUM_SRC);

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               we_srcp, we_mode, we_mask, we_intp;
  logic [NUM_SRC-1:0] src_pend;
  logic [NUM_SRC-1:0] mode;
  logic [NUM_SRC-1:0] mask;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] win;
  logic [NUM_SRC-1:0] int_pend;
  logic [IDX_W-1:0]   index;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign we_srcp = reg_we && (reg_addr == REG_SRCP);
  assign we_mode = reg_we && (reg_addr == REG_MODE);
  assign we_mask = reg_we && (reg_addr == REG_MASK);
  assign we_intp = reg_we && (reg_addr == REG_INTP);

  intc_src_pend #(.N(NUM_SRC)) u_src_pend (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .evt      (src_evt),
    .clr_en   (we_srcp),
    .clr_bits (reg_wdata),
    .pend     (src_pend)
  );

  intc_cfg #(.N(NUM_SRC)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .mode_we (we_mode),
    .mask_we (we_mask),
    .wdata   (reg_wdata),
    .mode    (mode),
    .mask    (mask)
  );

  assign cand = src_pend & ~mode & ~mask;

  intc_prio_pick #(.N(NUM_SRC)) u_arb (
    .req   (cand),
    .grant (win)
  );

  intc_int_pend #(.N(NUM_SRC), .IDX_W(IDX_W)) u_int_pend (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .win      (win),
    .clr_en   (we_intp),
    .clr_bits (reg_wdata),
    .pend     (int_pend),
    .index    (index)
  );

  assign fast_req = |(src_pend & mode);
  assign norm_req = |int_pend;

  always_comb begin
    case (reg_addr)
      REG_SRCP:  reg_rdata = src_pend;
      REG_MODE:  reg_rdata = mode;
      REG_MASK:  reg_rdata = mask;
      REG_INTP:  reg_rdata = int_pend;
      REG_INDEX: reg_rdata = NUM_SRC'(index);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_evt,
  input logic [NUM_SRC-1:0] src_pend,
  input logic [NUM_SRC-1:0] mode,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] int_pend,
  input logic [IDX_W-1:0]   index
);
  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((src_pend & $past(src_evt)) == $past(src_evt)));

  // R4
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mode));

  // R5
  fast_not_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend == '0) |=> ((int_pend & $past(mode)) == '0));

  // R6
  masked_not_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend == '0) |=> ((int_pend & $past(mask)) == '0));

  // R7
  intp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(int_pend));

  // R8
  intp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend != '0) |=> ((int_pend == $past(int_pend)) || (int_pend == '0)));

  // R11
  index_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_pend == '0) |-> (index == '0));
endmodule

bind intc_core intc_core_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .src_evt  (src_evt),
  .src_pend (src_pend),
  .mode     (mode),
  .mask     (mask),
  .int_pend (int_pend),
  .index    (index)
);

// File: tb/intc_core_bench.sv
module intc_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;

  logic          clk;
  logic          rst_n;
  logic [NS-1:0] src_evt;
  logic          reg_we;
  logic [2:0]    reg_addr;
  logic [NS-1:0] reg_wdata;
  logic [NS-1:0] reg_rdata;
  logic          fast_req;
  logic          norm_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  intc_core #(.NUM_SRC(NS)) u_intc_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .fast_req  (fast_req),
    .norm_req  (norm_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NS-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [NS-1:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic pulse(input logic [NS-1:0] e);
    @(negedge clk);
    src_evt = e;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic t_reset();
    logic [NS-1:0] v;
    rd(3'd0, v); check("R1 srcpend", v, '0);
    rd(3'd1, v); check("R1 mode", v, '0);
    rd(3'd2, v); check("R1 mask", v, '1);
    rd(3'd3, v); check("R1 intpend", v, '0);
    rd(3'd4, v); check("R1 index", v, '0);
    check("R1 fast_req", NS'(fast_req), '0);
    check("R1 norm_req", NS'(norm_req), '0);
  endtask

  task automatic t_masked();
    logic [NS-1:0] v;
    pulse((32'd1 << 5) | (32'd1 << 12));
    rd(3'd0, v); check("R2 two events", v, (32'd1 << 5) | (32'd1 << 12));
    cyc(); cyc();
    check("R6 norm_req masked", NS'(norm_req), '0);
    rd(3'd3, v); check("R6 intpend masked", v, '0);
    wr(3'd0, '1);
    wr(3'd2, '0);
  endtask

  task automatic t_priority();
    logic [NS-1:0] v;
    pulse((32'd1 << 9) | (32'd1 << 20));
    check("R9 norm_req not yet", NS'(norm_req), '0);
    cyc();
    check("R9 norm_req set", NS'(norm_req), 1);
    rd(3'd3, v); check("R7 winner", v, 32'd1 << 9);
    rd(3'd4, v); check("R11 index 9", v, 32'd9);
    wr(3'd0, 32'd1 << 9);
    rd(3'd3, v); check("R8 still held", v, 32'd1 << 9);
    wr(3'd3, 32'd1 << 9);
    rd(3'd3, v); check("R10 cleared gap", v, '0);
    cyc();
    rd(3'd3, v); check("R7 next winner", v, 32'd1 << 20);
    rd(3'd4, v); check("R11 index 20", v, 32'd20);
    wr(3'd0, 32'd1 << 20);
    wr(3'd3, 32'd1 << 20);
    cyc();
    check("R9 norm_req idle", NS'(norm_req), '0);
  endtask

  task automatic t_hold();
    logic [NS-1:0] v;
    pulse(32'd1 << 20);
    cyc();
    pulse(32'd1 << 1);
    cyc(); cyc();
    rd(3'd3, v); check("R8 no displace", v, 32'd1 << 20);
    wr(3'd0, 32'd1 << 20);
    wr(3'd3, '1);
    cyc();
    rd(3'd3, v); check("R8 load after empty", v, 32'd1 << 1);
    rd(3'd4, v); check("R11 index 1", v, 32'd1);
    wr(3'd0, 32'd1 << 1);
    wr(3'd3, '1);
  endtask

  task automatic t_reselect();
    logic [NS-1:0] v;
    pulse(32'd1 << 3);
    cyc();
    rd(3'd3, v); check("R10 loaded", v, 32'd1 << 3);
    wr(3'd3, 32'd1 << 3);
    check("R10 norm_req gap", NS'(norm_req), '0);
    cyc();
    rd(3'd3, v); check("R10 reselected", v, 32'd1 << 3);
    wr(3'd0, 32'd1 << 3);
    wr(3'd3, 32'd1 << 3);
    cyc();
    rd(3'd3, v); check("R10 proper order", v, '0);
  endtask

  task automatic t_fast();
    logic [NS-1:0] v;
    wr(3'd1, 32'h0000_0050);
    rd(3'd1, v); check("R4 lowest kept", v, 32'h0000_0010);
    wr(3'd2, 32'd1 << 4);
    pulse(32'd1 << 4);
    check("R5 fast_req masked src", NS'(fast_req), 1);
    cyc(); cyc();
    check("R5 no norm_req", NS'(norm_req), '0);
    rd(3'd3, v); check("R5 intpend empty", v, '0);
    wr(3'd0, 32'd1 << 4);
    check("R5 fast_req drops", NS'(fast_req), '0);
    wr(3'd1, '0);
  endtask

  task automatic t_evt_vs_clear();
    logic [NS-1:0] v;
    wr(3'd2, '1);
    pulse((32'd1 << 7) | (32'd1 << 8));
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = (32'd1 << 7) | (32'd1 << 8);
    src_evt = 32'd1 << 7;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; src_evt = '0;
    rd(3'd0, v); check("R3 event beats clear", v, 32'd1 << 7);
    pulse((32'd1 << 2) | (32'd1 << 30));
    wr(3'd0, 32'd1 << 30);
    rd(3'd0, v); check("R3 partial clear", v, (32'd1 << 2) | (32'd1 << 7));
    wr(3'd0, '1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_evt = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_masked();
    t_priority();
    t_hold();
    t_reselect();
    t_fast();
    t_evt_vs_clear();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule